// File: doc/BRIEF.md
# Plug-and-play card state controller

This block is the card-side control logic of a plug-and-play expansion card on a legacy 8-bit I/O bus. It tracks the card through four states: locked (waiting for the key), Sleep, Isolation and Config. It keeps the card select number (CSN) and the selected logical device, and it runs the resource-data read handshake. The host reaches it through a synchronous register port. An address strobe latches a register index. A write strobe carries data to the indexed register. A read strobe returns the indexed register on `rdata` in the following cycle.

Unlocking is modelled by a one-cycle `key_unlock` pulse. The key-sequence recogniser, the serial-isolation bit comparison and the bus electrical timing sit outside this block. The resource data comes from a small internal ROM whose contents are computed from the byte index.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (locked), `csn_o` is 0, `rd_port_o` is 0, `ldev_reset_o` is 0, `rdata` is 0, the selected logical device is 0 and the resource pointer is at byte 0 with the ready flag set.
- R2: In the locked state (0), a `key_unlock` pulse moves the card to Sleep (1) on the next edge. Every address-port and data-port write is ignored while locked.
- R3: A data write to index 0x00 in Isolation (2) or Config (3) relocates the read port: `rd_port_o` becomes {data, 2'b00}.
- R4: A data write to index 0x02 in any unlocked state works as follows. Bit 0 gives a one-cycle `ldev_reset_o` pulse and keeps the CSN. Bit 1 returns the card to the locked state and keeps the CSN. Bit 2 clears the CSN to 0. Nothing is stored, and a read of 0x02 returns 0x00.
- R5: A data write to index 0x03 in Sleep acts only when the data equals the CSN. The card then moves to Isolation if the data is 0, or to Config otherwise. A mismatch leaves the state unchanged.
- R6: A wake that acts also returns the resource pointer to byte 0 and sets the ready flag.
- R7: A read of index 0x04 in Config while ready returns resource byte k = (k*37 + 90) mod 256 and advances k. The pointer wraps to 0 after byte ROM_DEPTH-1.
- R8: A read of index 0x05 returns the ready flag in bit 0 (other bits 0). Ready drops for exactly BUSY_CYCLES cycles after each consuming read of 0x04. A read of 0x04 while not ready returns 0x00 and does not advance the pointer.
- R9: Index 0x06 holds the CSN. It is written in Isolation or Config and can be read back.
- R10: Index 0x07 holds the logical device number. A value of NUM_LDN or more is ignored. With NUM_LDN = 1 it always reads 0x00.
- R11: Reads return data only in Config. In any other state a read returns 0x00 and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_unlock | input | 1 | One-cycle pulse: key sequence recognised |
| addr_wr | input | 1 | Address-port write strobe; `wdata` is the register index |
| wdata_wr | input | 1 | Data-port write strobe to the indexed register |
| rd_en | input | 1 | Read strobe at the relocatable read port |
| wdata | input | 8 | Write data / index |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| state_o | output | 2 | 0 locked, 1 Sleep, 2 Isolation, 3 Config |
| csn_o | output | 8 | Current card select number |
| rd_port_o | output | 10 | Read-port address |
| ldev_reset_o | output | 1 | One-cycle pulse resetting logical-device configuration |

## Verification
Every result appears after exactly one register stage. State, CSN, read-port location and the `ldev_reset_o` pulse change at the edge that samples the write strobe. `rdata` carries the value of the read registered at the edge that samples `rd_en`. Ready stays low for BUSY_CYCLES edges after a consuming read. The bench drives each strobe for one cycle from the falling edge and samples on the next falling edge, just after the edge that acts. Reads during the busy window are placed by counting idle cycles, so they fall on a known side of the ready boundary.

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl #(
  parameter int ROM_DEPTH   = 16,
  parameter int BUSY_CYCLES = 3,
  parameter int NUM_LDN     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_unlock,
  input  logic       addr_wr,
  input  logic       wdata_wr,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [1:0] state_o,
  output logic [7:0] csn_o,
  output logic [9:0] rd_port_o,
  output logic       ldev_reset_o
);
  localparam int PTR_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

  typedef enum logic [1:0] {LOCKED = 2'd0, SLEEP = 2'd1, ISOL = 2'd2, CONF = 2'd3} st_t;

  st_t              st;
  logic [7:0]       idx, csn, port_q, rdata_q;
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] cnt;
  logic [LDN_W-1:0] ldn;
  logic             ldev_q;

  wire unlocked  = (st != LOCKED);
  wire iso_cfg   = (st == ISOL) || (st == CONF);
  wire ready     = (cnt == '0);
  wire wr_hit    = wdata_wr && unlocked;
  wire wake_hit  = wr_hit && idx == 8'h03 && st == SLEEP && wdata == csn;
  wire take_byte = rd_en && st == CONF && idx == 8'h04 && ready;
  wire [7:0] rom_byte = 8'(ptr) * 8'd37 + 8'd90;

  logic [7:0] rd_val;
  always_comb begin
    rd_val = 8'h00;
    if (st == CONF) begin
      case (idx)
        8'h04:   rd_val = ready ? rom_byte : 8'h00;
        8'h05:   rd_val = {7'd0, ready};
        8'h06:   rd_val = csn;
        8'h07:   rd_val = 8'(ldn);
        default: rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= LOCKED;
      idx     <= 8'h00;
      csn     <= 8'h00;
      port_q  <= 8'h00;
      rdata_q <= 8'h00;
      ptr     <= '0;
      cnt     <= '0;
      ldev_q  <= 1'b0;
    end else begin
      ldev_q <= 1'b0;
      if (!ready) cnt <= cnt - 1'b1;
      if (st == LOCKED && key_unlock) st <= SLEEP;
      if (addr_wr && unlocked) idx <= wdata;
      if (wr_hit) begin
        case (idx)
          8'h00: if (iso_cfg) port_q <= wdata;
          8'h02: begin
            ldev_q <= wdata[0];
            if (wdata[1]) st <= LOCKED;
            if (wdata[2]) csn <= 8'h00;
          end
          8'h06: if (iso_cfg) csn <= wdata;
          default: ;
        endcase
      end
      if (wake_hit) begin
        st  <= (wdata == 8'h00) ? ISOL : CONF;
        ptr <= '0;
        cnt <= '0;
      end
      if (rd_en) rdata_q <= rd_val;
      if (take_byte) begin
        ptr <= (ptr == PTR_W'(ROM_DEPTH - 1)) ? '0 : ptr + 1'b1;
        cnt <= CNT_W'(BUSY_CYCLES);
      end
    end
  end

  generate
    if (NUM_LDN > 1) begin : g_multi_ldn
      always_ff @(posedge clk) begin
        if (!rst_n) ldn <= '0;
        else if (wr_hit && idx == 8'h07 && iso_cfg && int'(wdata) < NUM_LDN)
          ldn <= LDN_W'(wdata);
      end
    end else begin : g_single_ldn
      assign ldn = '0;
    end
  endgenerate

  assign rdata        = rdata_q;
  assign state_o      = st;
  assign csn_o        = csn;
  assign rd_port_o    = {port_q, 2'b00};
  assign ldev_reset_o = ldev_q;

  AST_KEY_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOCKED && key_unlock) |=> st == SLEEP); // R2
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LOCKED && !key_unlock) |=> st == LOCKED && $stable(csn) && $stable(idx)); // R2
  AST_WAKE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SLEEP && wdata_wr && idx == 8'h03 && wdata != csn && !(addr_wr)) |=> st == SLEEP); // R5
  AST_CSN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && idx == 8'h02 && wdata[2]) |=> csn == 8'h00); // R4
  AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |=> !ready); // R8
  AST_WAKE_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |=> ptr == '0 && ready); // R6
endmodule

// File: tb/pnp_card_ctrl_tb_top.sv
module pnp_card_ctrl_tb_top;
  localparam int ROM_DEPTH = 16;
  localparam int BUSY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic key_unlock = 0, addr_wr = 0, wdata_wr = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic [1:0] state_o;
  logic [7:0] csn_o;
  logic [9:0] rd_port_o;
  logic ldev_reset_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pnp_card_ctrl #(.ROM_DEPTH(ROM_DEPTH), .BUSY_CYCLES(BUSY), .NUM_LDN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .key_unlock(key_unlock), .addr_wr(addr_wr),
    .wdata_wr(wdata_wr), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .state_o(state_o), .csn_o(csn_o), .rd_port_o(rd_port_o), .ldev_reset_o(ldev_reset_o));

  localparam logic [3:0] KEY = 1, AW = 2, DW = 3, RD = 4, ST = 5, PT = 6, ID = 7;
  localparam int NV = 52;
  localparam logic [23:0] VEC [NV] = '{
    {KEY,8'h00,8'h00,4'd2}, {ST,8'h00,8'h01,4'd2},                           // R2 unlock
    {AW,8'h03,8'h00,4'd5}, {DW,8'h00,8'h00,4'd5}, {ST,8'h00,8'h02,4'd5},     // R5 wake 0
    {AW,8'h06,8'h00,4'd9}, {DW,8'h05,8'h00,4'd9},                            // R9 csn=5
    {AW,8'h00,8'h00,4'd3}, {DW,8'h80,8'h00,4'd3}, {PT,8'h00,8'h80,4'd3},     // R3
    {AW,8'h06,8'h00,4'd11}, {RD,8'h00,8'h00,4'd11},                          // R11
    {AW,8'h02,8'h00,4'd4}, {DW,8'h02,8'h00,4'd4}, {ST,8'h00,8'h00,4'd4},     // R4 bit1
    {AW,8'h07,8'h00,4'd2}, {DW,8'h09,8'h00,4'd2},                            // R2 ignored
    {KEY,8'h00,8'h00,4'd2}, {ST,8'h00,8'h01,4'd2},
    {AW,8'h03,8'h00,4'd5}, {DW,8'h04,8'h00,4'd5}, {ST,8'h00,8'h01,4'd5},     // R5 mismatch
    {DW,8'h05,8'h00,4'd5}, {ST,8'h00,8'h03,4'd5},                            // R5 to config
    {AW,8'h06,8'h00,4'd9}, {RD,8'h00,8'h05,4'd2},                            // R2/R9
    {AW,8'h07,8'h00,4'd10}, {DW,8'h02,8'h00,4'd10}, {RD,8'h00,8'h02,4'd10},  // R10
    {DW,8'h09,8'h00,4'd10}, {RD,8'h00,8'h02,4'd10},
    {DW,8'h03,8'h00,4'd10}, {RD,8'h00,8'h03,4'd10},
    {AW,8'h02,8'h00,4'd4}, {RD,8'h00,8'h00,4'd4},                            // R4 read 0
    {AW,8'h05,8'h00,4'd8}, {RD,8'h00,8'h01,4'd8},                            // R8
    {AW,8'h04,8'h00,4'd7}, {RD,8'h00,8'h5A,4'd7}, {RD,8'h00,8'h00,4'd8},     // R7 R8
    {ID,8'h04,8'h00,4'd8}, {RD,8'h00,8'h7F,4'd7},
    {AW,8'h05,8'h00,4'd8}, {RD,8'h00,8'h00,4'd8},
    {ID,8'h03,8'h00,4'd8}, {RD,8'h00,8'h01,4'd8},
    {AW,8'h02,8'h00,4'd4}, {DW,8'h04,8'h00,4'd4},                            // R4 bit2
    {AW,8'h06,8'h00,4'd4}, {RD,8'h00,8'h00,4'd4},
    {DW,8'h07,8'h00,4'd9}, {RD,8'h00,8'h07,4'd9}
  };

  task automatic chk(input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] op, input logic [7:0] d);
    wdata = d;
    key_unlock = (op == KEY); addr_wr = (op == AW); wdata_wr = (op == DW); rd_en = (op == RD);
    @(negedge clk);
    key_unlock = 0; addr_wr = 0; wdata_wr = 0; rd_en = 0;
  endtask

  function automatic int rom(input int k);
    return (k * 37 + 90) % 256;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(1, state_o, 0); chk(1, csn_o, 0); chk(1, rd_port_o, 0);
    chk(1, ldev_reset_o, 0); chk(1, rdata, 0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op; logic [7:0] a, e; int rq;
      {op, a, e} = VEC[i][23:4];
      rq = int'(VEC[i][3:0]);
      case (op)
        ST: chk(rq, state_o, e);
        PT: chk(rq, rd_port_o, {e, 2'b00});
        ID: repeat (a) @(negedge clk);
        RD: begin strobe(op, a); chk(rq, rdata, e); end
        default: strobe(op, a);
      endcase
    end

    // R4 bit0: one-cycle pulse, CSN and state kept
    strobe(AW, 8'h02); strobe(DW, 8'h01);
    chk(4, ldev_reset_o, 1); chk(4, csn_o, 7); chk(4, state_o, 3);
    @(negedge clk);
    chk(4, ldev_reset_o, 0);

    // R6 wake rewinds the pointer (two bytes were consumed earlier)
    strobe(DW, 8'h02); chk(4, state_o, 0); chk(4, csn_o, 7);
    strobe(KEY, 8'h00);
    strobe(AW, 8'h03); strobe(DW, 8'h07); chk(5, state_o, 3);
    strobe(AW, 8'h05); strobe(RD, 8'h00); chk(6, rdata, 1);
    strobe(AW, 8'h04); strobe(RD, 8'h00); chk(6, rdata, rom(0));

    // R7 sequence and wrap
    for (int k = 1; k <= ROM_DEPTH; k++) begin
      repeat (BUSY) @(negedge clk);
      strobe(RD, 8'h00);
      chk(7, rdata, rom(k % ROM_DEPTH));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule